// File: doc/BRIEF.md
# Interrupt translation control register file

This block is the memory-mapped control register file for an interrupt translation service. Software reaches it over a simple register bus that carries an offset, a size flag that picks a 32-bit or a 64-bit access, separate read and write strobes, and write data. Every access gets a response one cycle later, together with an error flag. The block holds these registers:

- a control word with an enable bit
- a read-only feature (type) word
- a command queue base
- command queue read and write pointers
- eight translation table bases

Software can reach either 32-bit half of a 64-bit register. Once the service is enabled, the block locks the queue base and table bases against writes. Each time a control write leaves the enable bit set, the block sends a one-cycle pulse so that a downstream decoder captures the table and queue parameters.

The command read pointer cannot be written from the bus. Only an internal update port changes it, driven by the command engine, which lives outside this block. Bus writes can still clear the read pointer as a side effect.

Top module: `itr_regfile`

## Requirements
- R1: After reset, every register reads zero except the type register, which reads the `TYPE_VAL` parameter. `svc_enabled`, `cfg_pulse` and all response outputs are low.
- R2: A read strobe raises `reg_rvalid`, and a write strobe raises `reg_wack`, for exactly one cycle on the clock edge after the strobe. `reg_err` is valid only in that same cycle, and the two valid signals are never high together.
- R3: Offsets and sizes:
  - The control word is at 0x000 and allows 32-bit access only.
  - The type register is at 0x008 and is read-only.
  - The command queue base is at 0x080.
  - The write pointer is at 0x088.
  - The read pointer is at 0x090 and is read-only.
  - The tables occupy 0x100–0x13F.
  - A 32-bit access needs offset bits [1:0] = 0, and a 64-bit access needs bits [2:0] = 0.
  - Any other access, including a write to a read-only register, gets `reg_err` and changes no state.
- R4: A write to the control word ORs the low 32 data bits into the stored word. Bits can be set and never cleared.
- R5: A control write that leaves bit 0 (enable) set clears the read pointer to zero. It also raises `cfg_pulse` for one cycle, in the same cycle as `reg_wack`. Such a write pulses again even if the enable bit was already set.
- R6: While the enable bit is set, writes to the queue base and to any table base are acknowledged without error and leave the stored value unchanged.
- R7: An unlocked write that covers the low half of the queue base clears the read pointer. Such a write is a 32-bit write at 0x080 or a 64-bit write. A write to the high half only (0x084) does not clear it.
- R8: The write pointer takes 32-bit writes to either half and 64-bit writes at all times, whether or not the service is enabled.
- R9: A 32-bit read at +0 returns bits [31:0] of the register in `reg_rdata[31:0]`, with the upper 32 bits zero. A 32-bit read at +4 returns bits [63:32] the same way. A 64-bit read returns all 64 bits.
- R10: Table register n sits at 0x100 + 8·n. Offset bit 2 picks the high half for 32-bit accesses.
- R11: A table write stores its data ANDed with `TBL_MASK`. A 32-bit write applies only the matching half of the mask and keeps the other half.
- R12: The read pointer takes `rp_set_val` when `rp_set` is high. In the same cycle, a bus clear from R5 or R7 wins over the update port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | ADDR_W | Byte offset of the access |
| reg_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe (takes precedence over `reg_rd`) |
| reg_wdata | input | 64 | Write data; 32-bit writes use bits [31:0] |
| reg_rdata | output | 64 | Read data, valid with `reg_rvalid`; zero on error |
| reg_rvalid | output | 1 | Read response |
| reg_wack | output | 1 | Write response |
| reg_err | output | 1 | Error flag for the current response |
| rp_set | input | 1 | Internal read pointer update strobe |
| rp_set_val | input | 64 | New read pointer value |
| svc_enabled | output | 1 | Current state of the enable bit |
| cfg_pulse | output | 1 | Parameter capture pulse |

## Verification
A wrong lock, mask or merge inside the block does not show at the ports until the affected register is read back. It then appears two cycles after the faulty write, as a `reg_rdata` mismatch. The bench therefore follows each write group with read-backs of every register involved. A wrong read pointer clear or update is caught by the next pointer read. A decode fault shows at once, in the response cycle, as a wrong `reg_err`. The control path shows in that same cycle through `cfg_pulse` and `svc_enabled`.

// File: rtl/itr_regfile.sv
module itr_regfile #(
  parameter int          ADDR_W   = 16,
  parameter logic [63:0] TYPE_VAL = 64'h0000_0010_0004_2B19,
  parameter logic [63:0] TBL_MASK = 64'hC7FF_FFFF_FFFF_F3FF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wide,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [63:0]       reg_wdata,
  output logic [63:0]       reg_rdata,
  output logic              reg_rvalid,
  output logic              reg_wack,
  output logic              reg_err,
  input  logic              rp_set,
  input  logic [63:0]       rp_set_val,
  output logic              svc_enabled,
  output logic              cfg_pulse
);
  localparam int NTBL  = 8;
  localparam int IDX_W = $clog2(NTBL);
  localparam logic [ADDR_W-1:0] A_CTRL = 'h000;
  localparam logic [ADDR_W-1:0] A_TYPE = 'h008;
  localparam logic [ADDR_W-1:0] A_CQB  = 'h080;
  localparam logic [ADDR_W-1:0] A_CWR  = 'h088;
  localparam logic [ADDR_W-1:0] A_CRD  = 'h090;
  localparam logic [ADDR_W-1:0] A_TBL  = 'h100;

  logic [31:0]            ctrl;
  logic [63:0]            cqb, cwr, crd;
  logic [NTBL-1:0][63:0]  tbl;

  wire hi   = reg_addr[2];
  wire ok32 = !reg_wide && reg_addr[1:0] == 2'b00;
  wire ok64 = reg_wide && reg_addr[2:0] == 3'b000;
  wire ok   = ok32 || ok64;
  wire [ADDR_W-4:0] qw = reg_addr[ADDR_W-1:3];

  wire s_ctrl = ok32 && reg_addr == A_CTRL;
  wire s_type = ok && qw == A_TYPE[ADDR_W-1:3];
  wire s_cqb  = ok && qw == A_CQB[ADDR_W-1:3];
  wire s_cwr  = ok && qw == A_CWR[ADDR_W-1:3];
  wire s_crd  = ok && qw == A_CRD[ADDR_W-1:3];
  wire s_tbl  = ok && reg_addr[ADDR_W-1:IDX_W+3] == A_TBL[ADDR_W-1:IDX_W+3];
  wire [IDX_W-1:0] tix = reg_addr[IDX_W+2:3];

  wire rd_ok  = s_ctrl | s_type | s_cqb | s_cwr | s_crd | s_tbl;
  wire wr_ok  = s_ctrl | s_cqb | s_cwr | s_tbl;
  wire wr     = reg_wr && wr_ok;
  wire locked = ctrl[0];
  wire [31:0] ctrl_nx = ctrl | reg_wdata[31:0];
  wire rp_clr = wr && ((s_ctrl && ctrl_nx[0]) || (s_cqb && !locked && !hi));

  function automatic logic [63:0] merge(input logic [63:0] old, input logic [63:0] d,
                                        input logic w, input logic h);
    if (w) return d;
    return h ? {d[31:0], old[31:0]} : {old[63:32], d[31:0]};
  endfunction

  logic [63:0] rval;
  always_comb begin
    rval = '0;
    if (s_ctrl)      rval = {32'b0, ctrl};
    else if (s_type) rval = TYPE_VAL;
    else if (s_cqb)  rval = cqb;
    else if (s_cwr)  rval = cwr;
    else if (s_crd)  rval = crd;
    else if (s_tbl)  rval = tbl[tix];
  end
  wire [63:0] rsel = reg_wide ? rval : {32'b0, hi ? rval[63:32] : rval[31:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0; cqb <= '0; cwr <= '0; crd <= '0; tbl <= '0;
      reg_rdata <= '0; reg_rvalid <= 1'b0; reg_wack <= 1'b0; reg_err <= 1'b0;
      cfg_pulse <= 1'b0;
    end else begin
      reg_rvalid <= reg_rd && !reg_wr;
      reg_wack   <= reg_wr;
      reg_err    <= reg_wr ? !wr_ok : (reg_rd && !rd_ok);
      reg_rdata  <= (reg_rd && !reg_wr && rd_ok) ? rsel : '0;
      cfg_pulse  <= wr && s_ctrl && ctrl_nx[0];
      if (wr && s_ctrl) ctrl <= ctrl_nx;
      if (wr && s_cqb && !locked) cqb <= merge(cqb, reg_wdata, reg_wide, hi);
      if (wr && s_cwr) cwr <= merge(cwr, reg_wdata, reg_wide, hi);
      if (wr && s_tbl && !locked) tbl[tix] <= merge(tbl[tix], reg_wdata, reg_wide, hi) & TBL_MASK;
      if (rp_clr)      crd <= '0;
      else if (rp_set) crd <= rp_set_val;
    end
  end

  assign svc_enabled = ctrl[0];

  AST_ERR_HAS_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    reg_err |-> (reg_rvalid || reg_wack)); // R2
  AST_ONE_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_rvalid && reg_wack)); // R2
  AST_CTRL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl & $past(ctrl)) == $past(ctrl)); // R4
  AST_PULSE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_pulse |-> (reg_wack && !reg_err && svc_enabled)); // R5
  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    svc_enabled |=> ($stable(cqb) && $stable(tbl))); // R6
  AST_RP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!rp_set && !reg_wr) |=> $stable(crd)); // R12
endmodule

// File: tb/itr_regfile_test.sv
`timescale 1ns/1ps
module itr_regfile_test;
  localparam logic [63:0] TV = 64'h0000_0010_0004_2B19;
  localparam logic [63:0] TM = 64'hC7FF_FFFF_FFFF_F3FF;

  logic clk = 0, rst_n = 0;
  logic [15:0] reg_addr = 0;
  logic reg_wide = 0, reg_rd = 0, reg_wr = 0, rp_set = 0;
  logic [63:0] reg_wdata = 0, rp_set_val = 0;
  logic [63:0] reg_rdata;
  logic reg_rvalid, reg_wack, reg_err, svc_enabled, cfg_pulse;

  always #2 clk = ~clk;

  itr_regfile #(.ADDR_W(16), .TYPE_VAL(TV), .TBL_MASK(TM)) uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wide(reg_wide),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .reg_wack(reg_wack), .reg_err(reg_err),
    .rp_set(rp_set), .rp_set_val(rp_set_val), .svc_enabled(svc_enabled),
    .cfg_pulse(cfg_pulse));

  int ncmp = 0, nbad = 0;
  bit started = 0, done = 0;
  string tag = "R1";

  logic [31:0] m_ctrl = 0;
  logic [63:0] m_cqb = 0, m_cwr = 0, m_crd = 0, nrp, v;
  logic [63:0] m_tbl [8];
  logic e_rv = 0, e_wa = 0, e_er = 0, e_pl = 0, en, hi;
  logic [63:0] e_rdata = 0;
  int a, rgn, ix;

  initial for (int i = 0; i < 8; i++) m_tbl[i] = 0;

  function automatic logic [63:0] put(input logic [63:0] o, input logic [63:0] d,
                                      input logic w, input logic h);
    if (w) return d;
    if (h) return {d[31:0], o[31:0]};
    return {o[63:32], d[31:0]};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0; m_cqb = 0; m_cwr = 0; m_crd = 0;
      for (int i = 0; i < 8; i++) m_tbl[i] = 0;
      e_rv = 0; e_wa = 0; e_er = 0; e_pl = 0; e_rdata = 0;
    end else begin
      a = int'(reg_addr); rgn = 0; hi = (a % 8) == 4; ix = (a - 256) / 8;
      if ((reg_rd || reg_wr) && (reg_wide ? (a % 8 == 0) : (a % 4 == 0))) begin
        if (a == 0 && !reg_wide) rgn = 1;
        else if (a / 8 == 1)  rgn = 2;
        else if (a / 8 == 16) rgn = 3;
        else if (a / 8 == 17) rgn = 4;
        else if (a / 8 == 18) rgn = 5;
        else if (a >= 256 && a < 320) rgn = 6;
      end
      en = m_ctrl[0];
      nrp = rp_set ? rp_set_val : m_crd;
      e_rv = reg_rd && !reg_wr; e_wa = reg_wr; e_pl = 0; e_rdata = 0; e_er = 0;
      if (reg_wr) begin
        e_er = !(rgn == 1 || rgn == 3 || rgn == 4 || rgn == 6);
        case (rgn)
          1: begin m_ctrl = m_ctrl | reg_wdata[31:0];
               if (m_ctrl[0]) begin nrp = 0; e_pl = 1; end end
          3: if (!en) begin m_cqb = put(m_cqb, reg_wdata, reg_wide, hi); if (!hi) nrp = 0; end
          4: m_cwr = put(m_cwr, reg_wdata, reg_wide, hi);
          6: if (!en) m_tbl[ix] = put(m_tbl[ix], reg_wdata, reg_wide, hi) & TM;
          default: ;
        endcase
      end else if (reg_rd) begin
        e_er = (rgn == 0);
        case (rgn)
          1: v = {32'b0, m_ctrl};
          2: v = TV;
          3: v = m_cqb;
          4: v = m_cwr;
          5: v = m_crd;
          6: v = m_tbl[ix];
          default: v = 0;
        endcase
        if (rgn != 0) e_rdata = reg_wide ? v : (hi ? {32'b0, v[63:32]} : {32'b0, v[31:0]});
      end
      m_crd = nrp;
    end
  end

  task automatic chk(input string nm, input logic [63:0] act, input logic [63:0] exp);
    ncmp++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s %s: actual %h expected %h", tag, nm, act, exp);
    end
  endtask

  always @(negedge clk) if (started) begin
    chk("rvalid", 64'(reg_rvalid), 64'(e_rv));
    chk("wack", 64'(reg_wack), 64'(e_wa));
    chk("err", 64'(reg_err), 64'(e_er));
    chk("cfg_pulse", 64'(cfg_pulse), 64'(e_pl));
    chk("svc_enabled", 64'(svc_enabled), 64'(m_ctrl[0]));
    chk("rdata", reg_rdata, e_rdata);
  end

  task automatic acc(input bit w, input bit wd, input int ad, input logic [63:0] d);
    reg_wr = w; reg_rd = !w; reg_wide = wd; reg_addr = ad[15:0]; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0; reg_rd = 0;
  endtask

  task automatic setrp(input logic [63:0] d);
    rp_set = 1; rp_set_val = d;
    @(negedge clk);
    rp_set = 0;
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      nbad++;
      $display("FAIL R2 watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    @(posedge clk); started = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    tag = "R1";
    acc(0, 0, 'h000, 0); acc(0, 1, 'h080, 0); acc(0, 1, 'h088, 0); acc(0, 1, 'h090, 0);
    for (int i = 0; i < 8; i++) acc(0, 1, 'h100 + 8 * i, 0);
    tag = "R9";
    acc(0, 0, 'h008, 0); acc(0, 0, 'h00C, 0); acc(0, 1, 'h008, 0);
    tag = "R8";
    acc(1, 0, 'h088, 64'h1234_5670); acc(1, 0, 'h08C, 64'hDEAD_BEEF);
    acc(0, 1, 'h088, 0); acc(0, 0, 'h088, 0); acc(0, 0, 'h08C, 0);
    acc(1, 1, 'h088, 64'h0123_4567_89AB_CDE0); acc(0, 1, 'h088, 0);
    tag = "R10";
    for (int i = 0; i < 8; i++) acc(1, 1, 'h100 + 8 * i, {32'h0505_0000 | i, 32'h0A0A_0000 | i});
    for (int i = 0; i < 8; i++) begin acc(0, 0, 'h100 + 8 * i, 0); acc(0, 0, 'h104 + 8 * i, 0); end
    acc(1, 0, 'h114, 64'h0000_0000_0102_0304); acc(0, 1, 'h110, 0);
    tag = "R11";
    acc(1, 1, 'h118, 64'hFFFF_FFFF_FFFF_FFFF); acc(0, 1, 'h118, 0);
    acc(1, 0, 'h124, 64'hFFFF_FFFF); acc(1, 0, 'h130, 64'hFFFF_FFFF);
    acc(0, 1, 'h120, 0); acc(0, 1, 'h130, 0);
    tag = "R12";
    setrp(64'h40); acc(0, 1, 'h090, 0); acc(0, 0, 'h094, 0);
    acc(1, 0, 'h090, 64'h1); acc(1, 1, 'h090, 64'h1); acc(0, 1, 'h090, 0);
    tag = "R7";
    acc(1, 0, 'h084, 64'h0000_0001); acc(0, 1, 'h090, 0);
    acc(1, 0, 'h080, 64'h8000_0400); acc(0, 1, 'h090, 0); acc(0, 1, 'h080, 0);
    setrp(64'h99); acc(1, 1, 'h080, 64'h8000_0000_0000_1000); acc(0, 1, 'h090, 0);
    tag = "R12";
    rp_set = 1; rp_set_val = 64'h55; acc(1, 0, 'h080, 64'h2000); rp_set = 0;
    acc(0, 1, 'h090, 0);
    tag = "R3";
    acc(1, 0, 'h008, 64'hFFFF); acc(1, 1, 'h008, 64'hFFFF);
    acc(1, 1, 'h000, 64'h1); acc(0, 1, 'h000, 0);
    acc(1, 0, 'h082, 64'h7); acc(1, 1, 'h084, 64'h7); acc(0, 1, 'h08C, 0);
    acc(0, 0, 'h200, 0); acc(1, 0, 'h140, 64'h3); acc(0, 0, 'h004, 0); acc(0, 0, 'h0FC, 0);
    acc(0, 0, 'h000, 0); acc(0, 1, 'h080, 0); acc(0, 1, 'h088, 0);
    tag = "R4";
    acc(1, 0, 'h000, 64'hF0); acc(0, 0, 'h000, 0);
    acc(1, 0, 'h000, 64'h0); acc(1, 0, 'h000, 64'h300); acc(0, 0, 'h000, 0);
    tag = "R5";
    setrp(64'h77);
    acc(1, 0, 'h000, 64'h1); acc(0, 1, 'h090, 0);
    setrp(64'h33);
    acc(1, 0, 'h000, 64'h0); acc(0, 1, 'h090, 0); acc(0, 0, 'h000, 0);
    tag = "R6";
    setrp(64'h21);
    acc(1, 1, 'h080, 64'hFFFF_0000); acc(1, 0, 'h084, 64'h5); acc(1, 0, 'h080, 64'h5);
    acc(1, 1, 'h100, 64'h1111); acc(1, 0, 'h10C, 64'h2222);
    acc(0, 1, 'h080, 0); acc(0, 1, 'h100, 0); acc(0, 1, 'h108, 0); acc(0, 1, 'h090, 0);
    tag = "R8";
    acc(1, 0, 'h08C, 64'hCAFE_F00D); acc(1, 1, 'h088, 64'h0000_0000_0000_0840);
    acc(1, 0, 'h088, 64'h0000_0880); acc(0, 1, 'h088, 0);
    tag = "R2";
    reg_rd = 1; reg_wr = 1; reg_wide = 0; reg_addr = 16'h0088; reg_wdata = 64'h1;
    @(negedge clk);
    reg_rd = 0; reg_wr = 0;
    acc(0, 1, 'h088, 0);
    repeat (3) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end
endmodule